// File: doc/BRIEF.md
# First-Hit Channel Address Encoder

This block watches 64 per-channel hit indicators and reports which channel fired first. On the first clock in which any enabled, unmasked channel shows a hit, it raises a fast flag and latches that channel's 6-bit number. If several channels show a hit in that same clock, the lowest channel number wins. The captured number then stays put, and later hits are ignored until a clear arrives.

Each channel offers two hit sources: a threshold-crossing indicator and a peak-found indicator. One configuration bit picks which of the two counts as a hit for all channels. A second bit switches the whole function on or off. A per-channel mask removes channels from the selection.

The flag and the address are cleared in one of two ways. The first is a synchronous acquisition-clear input. The second is an optional self-reset, which fires a fixed number of clock cycles after the flag rises. At a 100 MHz clock, the default of four cycles corresponds to 40 ns. The winning channel is found with a two-level tree: first an OR across each group of eight channels, then a selection inside the lowest active group.

Top module: `first_hit_encoder`

## Requirements
- R1: While reset is asserted, and after it is released, `fast_flag` is 0 and `first_addr` is 0 until a hit is captured.
- R2: With `fast_flag` low and `cfg_enable` high, a hit on any eligible channel during the cycle before a rising clock edge sets `fast_flag` at that edge. At the same edge, `first_addr` takes the channel's number (channel i gives address i, from 0 to 63).
- R3: When several eligible channels show hits in the same cycle, `first_addr` takes the lowest channel number among them.
- R4: When `cfg_at_peak` is 0, only `thr_hit` counts as a hit. When it is 1, only `peak_hit` counts. The unselected vector has no effect on either output.
- R5: A channel whose `chan_mask` bit is 1 never causes a capture and never wins the selection.
- R6: While `cfg_enable` is 0, hits cause no capture. A rising edge with `cfg_enable` at 0 leaves `fast_flag` and `first_addr` at 0.
- R7: While `fast_flag` is high, further hits do not change `first_addr`.
- R8: With `cfg_self_reset` at 1, `fast_flag` stays high for exactly `SR_CYCLES` clock cycles (default 4) and then returns to 0, with `first_addr` returning to 0. No new capture takes place on the clearing edge.
- R9: With `cfg_self_reset` at 0, a captured flag and address stay unchanged until `acq_clr` or `cfg_enable` going low clears them.
- R10: `acq_clr` high before a rising edge clears `fast_flag` and `first_addr` at that edge. It takes priority over a capture in the same cycle.
- R11: `first_addr` is 0 whenever `fast_flag` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock (100 MHz nominal) |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| acq_clr | input | 1 | Synchronous clear of flag and address |
| cfg_enable | input | 1 | Turns first-hit reporting on (1) or off (0) |
| cfg_at_peak | input | 1 | Hit source: 0 selects threshold crossing, 1 selects peak found |
| cfg_self_reset | input | 1 | 1 enables the timed automatic clear |
| chan_mask | input | 64 | Bit i = 1 excludes channel i |
| thr_hit | input | 64 | Per-channel threshold-crossing indicators |
| peak_hit | input | 64 | Per-channel peak-found indicators |
| fast_flag | output | 1 | High while a first hit is held |
| first_addr | output | 6 | Number of the first channel hit; 0 when no hit is held |

## Verification
The hardest case to reach from the ports is a new hit arriving on the very edge where the self-reset expires, or in the same cycle as `acq_clr`. In that case the clear must win, and the capture must happen one cycle later. The bench places hits deliberately on those edges. It also runs a long pseudo-random phase in which held hit levels overlap the self-reset expiry, so back-to-back capture and clear sequences occur many times. Ties are produced by driving several channels in one cycle, both across groups and within a single group, including channels 0 and 63.

// File: rtl/fhe_pkg.sv
package fhe_pkg;
  localparam int unsigned CH_COUNT   = 64;
  localparam int unsigned GROUP_SIZE = 8;
  localparam int unsigned GROUP_CNT  = CH_COUNT / GROUP_SIZE;
  localparam int unsigned ADDR_W     = $clog2(CH_COUNT);
  localparam int unsigned GSEL_W     = $clog2(GROUP_CNT);
  localparam int unsigned MSEL_W     = $clog2(GROUP_SIZE);

  typedef logic [ADDR_W-1:0]   ch_addr_t;
  typedef logic [CH_COUNT-1:0] ch_vec_t;

  typedef enum logic [0:0] {
    SRC_THRESHOLD = 1'b0,
    SRC_PEAK      = 1'b1
  } hit_src_e;
endpackage

// File: rtl/fhe_rst_sync.sv
module fhe_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] pipe_q;
  logic [STAGES-1:0] pipe_d;

  always_comb begin
    pipe_d = {pipe_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe_q <= '0;
    else        pipe_q <= pipe_d;
  end

  assign rst_n_sync = pipe_q[STAGES-1];
endmodule

// File: rtl/fhe_src_sel.sv
module fhe_src_sel
  import fhe_pkg::*;
#(
  parameter int unsigned N_CH = CH_COUNT
) (
  input  logic            cfg_enable,
  input  logic            cfg_at_peak,
  input  logic [N_CH-1:0] chan_mask,
  input  logic [N_CH-1:0] thr_hit,
  input  logic [N_CH-1:0] peak_hit,
  output logic [N_CH-1:0] elig
);
  hit_src_e src;
  assign src = hit_src_e'(cfg_at_peak);

  for (genvar ch = 0; ch < N_CH; ch++) begin : g_ch
    logic raw;
    always_comb begin
      unique case (src)
        SRC_PEAK:      raw = peak_hit[ch];
        default:       raw = thr_hit[ch];
      endcase
    end
    assign elig[ch] = raw & ~chan_mask[ch] & cfg_enable;
  end
endmodule

// File: rtl/fhe_tree.sv
module fhe_tree
  import fhe_pkg::*;
#(
  parameter int unsigned N_CH  = CH_COUNT,
  parameter int unsigned GSIZE = GROUP_SIZE
) (
  input  logic [N_CH-1:0]          elig,
  output logic                     any_hit,
  output logic [$clog2(N_CH)-1:0]  win_addr
);
  localparam int unsigned NGRP = N_CH / GSIZE;
  localparam int unsigned GW   = $clog2(NGRP);
  localparam int unsigned MW   = $clog2(GSIZE);

  logic [NGRP-1:0]  grp_any;
  logic [GW-1:0]    grp_sel;
  logic [GSIZE-1:0] members;
  logic [MW-1:0]    mem_sel;

  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    assign grp_any[g] = |elig[g*GSIZE +: GSIZE];
  end

  // first level: lowest active group
  always_comb begin
    grp_sel = '0;
    for (int g = NGRP-1; g >= 0; g--) begin
      if (grp_any[g]) grp_sel = GW'(g);
    end
  end

  assign members = elig[grp_sel*GSIZE +: GSIZE];

  // second level: lowest active member of that group
  always_comb begin
    mem_sel = '0;
    for (int m = GSIZE-1; m >= 0; m--) begin
      if (members[m]) mem_sel = MW'(m);
    end
  end

  assign any_hit  = |grp_any;
  assign win_addr = {grp_sel, mem_sel};
endmodule

// File: rtl/fhe_capture.sv
module fhe_capture #(
  parameter int unsigned AW         = 6,
  parameter int unsigned SR_CYCLES  = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          acq_clr,
  input  logic          cfg_enable,
  input  logic          cfg_self_reset,
  input  logic          any_hit,
  input  logic [AW-1:0] win_addr,
  output logic          flag,
  output logic [AW-1:0] addr
);
  localparam int unsigned CW = (SR_CYCLES > 1) ? $clog2(SR_CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(SR_CYCLES - 1);

  logic          flag_q, flag_d;
  logic [AW-1:0] addr_q, addr_d;
  logic [CW-1:0] cnt_q,  cnt_d;
  logic          upd_en;

  always_comb begin
    flag_d = flag_q;
    addr_d = addr_q;
    cnt_d  = cnt_q;
    if (acq_clr || !cfg_enable) begin
      flag_d = 1'b0;
      addr_d = '0;
      cnt_d  = '0;
    end else if (flag_q) begin
      if (cfg_self_reset && (cnt_q == LAST)) begin
        flag_d = 1'b0;
        addr_d = '0;
        cnt_d  = '0;
      end else if (cnt_q != LAST) begin
        cnt_d = cnt_q + 1'b1;
      end
    end else if (any_hit) begin
      flag_d = 1'b1;
      addr_d = win_addr;
      cnt_d  = '0;
    end
  end

  assign upd_en = (flag_d != flag_q) || (addr_d != addr_q) || (cnt_d != cnt_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
      addr_q <= '0;
      cnt_q  <= '0;
    end else if (upd_en) begin
      flag_q <= flag_d;
      addr_q <= addr_d;
      cnt_q  <= cnt_d;
    end
  end

  assign flag = flag_q;
  assign addr = addr_q;
endmodule

// File: rtl/first_hit_encoder.sv
module first_hit_encoder
  import fhe_pkg::*;
#(
  parameter int unsigned SR_CYCLES = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                acq_clr,
  input  logic                cfg_enable,
  input  logic                cfg_at_peak,
  input  logic                cfg_self_reset,
  input  logic [CH_COUNT-1:0] chan_mask,
  input  logic [CH_COUNT-1:0] thr_hit,
  input  logic [CH_COUNT-1:0] peak_hit,
  output logic                fast_flag,
  output logic [ADDR_W-1:0]   first_addr
);
  logic          rst_n_int;
  ch_vec_t       elig;
  logic          any_hit;
  ch_addr_t      win_addr;

  fhe_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  fhe_src_sel #(.N_CH(CH_COUNT)) u_src (
    .cfg_enable  (cfg_enable),
    .cfg_at_peak (cfg_at_peak),
    .chan_mask   (chan_mask),
    .thr_hit     (thr_hit),
    .peak_hit    (peak_hit),
    .elig        (elig)
  );

  fhe_tree #(.N_CH(CH_COUNT), .GSIZE(GROUP_SIZE)) u_tree (
    .elig     (elig),
    .any_hit  (any_hit),
    .win_addr (win_addr)
  );

  fhe_capture #(.AW(ADDR_W), .SR_CYCLES(SR_CYCLES)) u_cap (
    .clk            (clk),
    .rst_n          (rst_n_int),
    .acq_clr        (acq_clr),
    .cfg_enable     (cfg_enable),
    .cfg_self_reset (cfg_self_reset),
    .any_hit        (any_hit),
    .win_addr       (win_addr),
    .flag           (fast_flag),
    .addr           (first_addr)
  );
endmodule

// File: rtl/first_hit_encoder_chk.sv
module first_hit_encoder_chk
  import fhe_pkg::*;
#(
  parameter int unsigned SR_CYCLES = 4
) (
  input logic                clk,
  input logic                rst_n,
  input logic                acq_clr,
  input logic                cfg_enable,
  input logic                cfg_self_reset,
  input logic                fast_flag,
  input logic [ADDR_W-1:0]   first_addr
);
  int unsigned hi_len_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         hi_len_q <= 0;
    else if (fast_flag) hi_len_q <= (hi_len_q < SR_CYCLES + 2) ? hi_len_q + 1 : hi_len_q;
    else                hi_len_q <= 0;
  end

  // R11
  addr_zero_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fast_flag |-> (first_addr == '0));

  // R7
  addr_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fast_flag && $past(fast_flag)) |-> (first_addr == $past(first_addr)));

  // R10
  clear_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acq_clr |=> !fast_flag);

  // R6
  disabled_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_enable |=> !fast_flag);

  // R8
  self_reset_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fast_flag && cfg_self_reset) |-> (hi_len_q < SR_CYCLES));
endmodule

bind first_hit_encoder first_hit_encoder_chk #(.SR_CYCLES(SR_CYCLES)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .acq_clr        (acq_clr),
  .cfg_enable     (cfg_enable),
  .cfg_self_reset (cfg_self_reset),
  .fast_flag      (fast_flag),
  .first_addr     (first_addr)
);

// File: tb/first_hit_encoder_tb_top.sv
module first_hit_encoder_tb_top;
  localparam int SRC = 4;

  logic        clk;
  logic        rst_n;
  logic        acq_clr;
  logic        cfg_enable, cfg_at_peak, cfg_self_reset;
  logic [63:0] chan_mask, thr_hit, peak_hit;
  logic        fast_flag;
  logic [5:0]  first_addr;

  first_hit_encoder #(.SR_CYCLES(SRC)) dut_i (
    .clk(clk), .rst_n(rst_n), .acq_clr(acq_clr),
    .cfg_enable(cfg_enable), .cfg_at_peak(cfg_at_peak),
    .cfg_self_reset(cfg_self_reset), .chan_mask(chan_mask),
    .thr_hit(thr_hit), .peak_hit(peak_hit),
    .fast_flag(fast_flag), .first_addr(first_addr)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 0;

  // stimulus to apply on the next step
  bit        s_clr, s_en, s_pk, s_sr;
  bit [63:0] s_mask, s_thr, s_peak;

  // reference model state
  bit m_flag;
  int m_addr;
  int m_cnt;

  task automatic compare(input string tag);
    n_cmp++;
    if (fast_flag !== m_flag || int'(first_addr) != m_addr) begin
      n_bad++;
      $display("FAIL %s: flag=%0b addr=%0d expected flag=%0b addr=%0d at %0t",
               tag, fast_flag, first_addr, m_flag, m_addr, $time);
    end
  endtask

  task automatic step(input string tag);
    bit [63:0] src;
    int lo;
    @(negedge clk);
    compare(tag);
    acq_clr = s_clr; cfg_enable = s_en; cfg_at_peak = s_pk;
    cfg_self_reset = s_sr; chan_mask = s_mask; thr_hit = s_thr; peak_hit = s_peak;
    src = (s_pk ? s_peak : s_thr) & ~s_mask;
    lo = -1;
    for (int i = 63; i >= 0; i--) if (src[i]) lo = i;
    if (s_clr || !s_en) begin
      m_flag = 0; m_addr = 0; m_cnt = 0;
    end else if (m_flag) begin
      if (s_sr && m_cnt == SRC-1) begin
        m_flag = 0; m_addr = 0; m_cnt = 0;
      end else if (m_cnt < SRC-1) m_cnt++;
    end else if (lo >= 0) begin
      m_flag = 1; m_addr = lo; m_cnt = 0;
    end
  endtask

  task automatic quiet(input int n, input string tag);
    s_thr = '0; s_peak = '0; s_clr = 0;
    for (int k = 0; k < n; k++) step(tag);
  endtask

  task automatic clear(input string tag);
    s_thr = '0; s_peak = '0; s_clr = 1;
    step(tag);
    s_clr = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    int unsigned lf;
    rst_n = 0; acq_clr = 0; cfg_enable = 0; cfg_at_peak = 0; cfg_self_reset = 0;
    chan_mask = '0; thr_hit = '0; peak_hit = '0;
    s_clr = 0; s_en = 1; s_pk = 0; s_sr = 0; s_mask = '0; s_thr = '0; s_peak = '0;
    m_flag = 0; m_addr = 0; m_cnt = 0;
    repeat (3) @(negedge clk);
    compare("R1 in reset");
    rst_n = 1;
    quiet(4, "R1 after reset");

    // R2 single hit, then R7 lock, R9 hold
    s_thr[37] = 1; step("R2 hit ch37");
    s_thr = '0; s_thr[5] = 1; step("R2 capture ch37");
    s_thr = '0; s_thr[2] = 1; step("R7 later hit ignored");
    quiet(8, "R9 held without self-reset");
    clear("R10 clear");
    quiet(2, "R11 idle after clear");

    // R3 ties
    s_thr = '0; s_thr[50] = 1; s_thr[12] = 1; s_thr[10] = 1; step("R3 tie setup");
    quiet(2, "R3 lowest of 10/12/50");
    clear("R10 clear");
    s_thr = '0; s_thr[63] = 1; s_thr[0] = 1; step("R3 ends");
    quiet(1, "R3 ch0 over ch63");
    clear("R10 clear");
    s_thr = '0; s_thr[63] = 1; step("R2 ch63");
    quiet(1, "R2 ch63 captured");
    clear("R10 clear");
    s_thr = '0; s_thr[46] = 1; s_thr[41] = 1; s_thr[47] = 1; step("R3 same group");
    quiet(1, "R3 ch41 in group");
    clear("R10 clear");

    // R4 source select
    s_peak = '0; s_peak[3] = 1; s_thr = '0; step("R4 peak ignored in threshold mode");
    quiet(2, "R4 no capture from peak");
    s_pk = 1; s_peak = '0; s_peak[9] = 1; s_thr = '0; s_thr[2] = 1; step("R4 peak mode");
    quiet(2, "R4 ch9 from peak");
    clear("R10 clear");

    // R5 mask
    s_mask = '0; s_mask[9] = 1; s_peak = '0; s_peak[9] = 1; s_peak[20] = 1; step("R5 mask ch9");
    quiet(1, "R5 ch20 wins");
    clear("R10 clear");
    s_mask = '1; s_peak = '1; step("R5 all masked");
    quiet(2, "R5 no capture");
    s_mask = '0; s_pk = 0;

    // R6 disable
    s_en = 0; s_thr = '1; step("R6 disabled");
    step("R6 disabled hold"); step("R6 disabled hold");
    s_thr = '0; s_en = 1; step("R6 re-enable idle");
    s_thr[7] = 1; step("R6 capture then disable");
    s_thr = '0; s_en = 0; step("R6 flag up");
    s_en = 1; step("R6 cleared by disable");
    quiet(1, "R6 stays clear");

    // R10 clear beats simultaneous hit
    s_thr[30] = 1; s_clr = 1; step("R10 clear with hit");
    s_clr = 0; s_thr = '0; s_thr[31] = 1; step("R10 no capture");
    quiet(1, "R10 capture next");
    clear("R10 clear");

    // R8 self-reset, including a held hit across expiry
    s_sr = 1;
    s_thr = '0; s_thr[44] = 1; step("R8 hit");
    quiet(7, "R8 self-reset expiry");
    s_thr = '0; s_thr[18] = 1;
    for (int k = 0; k < 12; k++) step("R8 held hit recapture");
    quiet(6, "R8 idle");

    // pseudo-random sweep
    lf = 32'h1ACE5EED;
    for (int k = 0; k < 3000; k++) begin
      lf ^= lf << 13; lf ^= lf >> 17; lf ^= lf << 5;
      s_thr = '0; s_peak = '0;
      if (lf[3:0] < 4)  s_thr[lf[9:4]] = 1;
      if (lf[13:10] < 3) s_thr[lf[19:14]] = 1;
      if (lf[23:20] < 4) s_peak[lf[29:24]] = 1;
      s_clr = (lf[31:28] == 4'hF);
      s_pk  = (k >= 1500);
      s_mask = '0; s_mask[lf[27:22]] = lf[30];
      step(k < 1500 ? "R2 random threshold" : "R4 random peak");
    end
    s_clr = 0;
    quiet(8, "R8 random tail");

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule